// File: doc/BRIEF.md
# Locked-Access Watchdog Timer

This block is a watchdog timer behind a one-byte register bus with two registers: a setup register and a restart register. It counts incoming prescaled ticks. When the count reaches the selected terminal value, it raises a reset request for the rest of the chip. Software keeps the chip alive by writing the restart key, 8'hAC, to the restart register, which clears the count.

Misuse of the bus also raises the reset request. The bus carries a separate strobe that marks single-bit read-modify-write accesses. The following are treated as faults:
- a second write to the setup register;
- a setup write whose top three bits are not the required 3'b011;
- a single-bit write to the setup register;
- any single-bit access to the restart register;
- any restart value other than the key.

If the one accepted setup write sets the halt bit, the counter freezes and later setup writes are ignored.

The bus is a plain single-cycle register port. Every access completes in the cycle it is presented, so there is no back-pressure. Read data is combinational from the address. The reset request is a registered pulse. The system reset controller consumes it and drives `rst_n`, which returns the block to its post-reset state.

Top module: `wdt_guard`

## Requirements
- R1: After reset, exactly one byte-wide write to the setup register (bus_addr = 0) is accepted, unless the halt bit is set. Any later setup write raises wdt_reset in the next cycle.
- R2: A setup write with bus_bitop = 1 is never accepted. While not halted, it raises wdt_reset in the next cycle.
- R3: A setup write with bus_wdata[7:5] other than 3'b011, while not halted, raises wdt_reset in the next cycle and is not loaded.
- R4: An accepted setup write with bit 4 (halt) = 1 holds the counter at zero. All later setup writes are then ignored: no pulse, and the setup register read back is unchanged.
- R5: A byte-wide write of 8'hAC to the restart register (bus_addr = 1) clears the counter without a pulse. Any other written value raises wdt_reset in the next cycle.
- R6: Any read or write to the restart register with bus_bitop = 1 raises wdt_reset in the next cycle.
- R7: Reading bus_addr = 1 returns 8'h9A. Reading bus_addr = 0 returns the setup register, which reads 8'h67 after reset (tag 011, halt 0, span 7).
- R8: Setup bits 2:0 (span s) select a terminal count of 2^(4+s) ticks. The count is cleared by an accepted setup write, the restart key or an overflow. wdt_reset pulses in the cycle after the tick that completes the count, then again every 2^(4+s) ticks.
- R9: wdt_reset is a single-cycle pulse per event. Asserting rst_n returns the block to its post-reset state: setup register unwritten and reading 8'h67, counter zero.
- R10: The counter advances only in cycles where tick = 1. Without ticks, no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = setup register, 1 = restart register |
| bus_bitop | input | 1 | Marks the access as a single-bit read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tick | input | 1 | Prescaled count enable |
| wdt_reset | output | 1 | One-cycle internal reset request |

## Verification
The hardest state to reach is the halted watchdog. Only the single accepted setup write can enter it, so the stimulus first issues a valid write with the halt bit set. It then feeds a long run of ticks and an illegal second setup write, and checks that no pulse appears and that the setup read-back is unchanged. Overflow timing is exercised by holding tick high from the cycle after a setup write or key write. Each expected pulse cycle is computed from the span, including a key write placed partway through a count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] RESTART_KEY      = 8'hAC;
  localparam logic [7:0] RESTART_READBACK = 8'h9A;
  localparam logic [2:0] SETUP_TAG        = 3'b011;
  localparam int         SPAN_W           = 3;

  typedef enum logic {REG_SETUP = 1'b0, REG_KICK = 1'b1} reg_sel_e;

  typedef struct packed {
    logic [2:0]        tag;
    logic              halt;
    logic              spare;
    logic [SPAN_W-1:0] span;
  } setup_t;
endpackage

// File: rtl/wdt_access_guard.sv
module wdt_access_guard
  import wdt_pkg::*;
#(
  parameter int DEFAULT_SPAN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic       bus_bitop,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output setup_t     setup_q,
  output logic       halted,
  output logic       written,
  output logic       load,
  output logic       kick,
  output logic       fault
);
  logic is_setup, is_kick;
  setup_t incoming;

  assign is_setup = (bus_addr == REG_SETUP);
  assign is_kick  = (bus_addr == REG_KICK);
  assign incoming = setup_t'(bus_wdata);

  // Access legality decode
  always_comb begin
    fault = 1'b0;
    load  = 1'b0;
    kick  = 1'b0;
    if (bus_wr && is_setup && !halted) begin
      if (bus_bitop || written || incoming.tag != SETUP_TAG) fault = 1'b1;
      else load = 1'b1;
    end
    if (is_kick && (bus_wr || bus_rd) && bus_bitop) fault = 1'b1;
    if (bus_wr && is_kick && !bus_bitop) begin
      if (bus_wdata == RESTART_KEY) kick = 1'b1;
      else fault = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '{tag: SETUP_TAG, halt: 1'b0, spare: 1'b0, span: SPAN_W'(DEFAULT_SPAN)};
      written <= 1'b0;
      halted  <= 1'b0;
    end else if (load) begin
      setup_q <= incoming;
      written <= 1'b1;
      halted  <= incoming.halt;
    end
  end

  assign bus_rdata = is_kick ? RESTART_READBACK : setup_q;
endmodule

// File: rtl/wdt_span_decode.sv
module wdt_span_decode
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 4,
  parameter int SPANS    = 8,
  parameter int CNT_W    = 11
) (
  input  logic [SPAN_W-1:0] span,
  output logic [CNT_W-1:0]  last
);
  logic [CNT_W-1:0] terminal [SPANS];

  for (genvar i = 0; i < SPANS; i++) begin : g_term
    assign terminal[i] = CNT_W'((64'd1 << (BASE_EXP + i)) - 64'd1);
  end

  assign last = terminal[span];
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             hold,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = tick && !hold && !clear && (count == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (clear || hold || expire) count <= '0;
    else if (tick)                    count <= count + 1'b1;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_EXP     = 4,
  parameter int DEFAULT_SPAN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic       bus_bitop,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick,
  output logic       wdt_reset
);
  localparam int SPANS = 1 << SPAN_W;
  localparam int CNT_W = BASE_EXP + SPANS - 1;

  setup_t           setup_q;
  logic             halted_w, written_w, load_w, kick_w, fault_w, expire_w;
  logic [CNT_W-1:0] last_w, count_w;
  logic             req_q;

  wdt_access_guard #(.DEFAULT_SPAN(DEFAULT_SPAN)) u_guard (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_bitop(bus_bitop), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .setup_q(setup_q), .halted(halted_w),
    .written(written_w), .load(load_w), .kick(kick_w), .fault(fault_w)
  );

  wdt_span_decode #(.BASE_EXP(BASE_EXP), .SPANS(SPANS), .CNT_W(CNT_W)) u_span (
    .span(setup_q.span), .last(last_w)
  );

  wdt_tick_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(load_w | kick_w),
    .hold(halted_w), .last(last_w), .count(count_w), .expire(expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fault_w | expire_w;
  end

  assign wdt_reset = req_q;
endmodule

// File: rtl/wdt_guard_checker.sv
module wdt_guard_checker #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_addr,
  input logic             bus_bitop,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             tick,
  input logic             wdt_reset,
  input logic             halted,
  input logic             written,
  input logic [CNT_W-1:0] count
);
  // R1
  second_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && written && !halted) |=> wdt_reset);
  // R3
  bad_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && !halted && bus_wdata[7:5] != 3'b011) |=> wdt_reset);
  // R5
  wrong_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && !bus_bitop && bus_wdata != 8'hAC) |=> wdt_reset);
  // R6
  bitop_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr && bus_bitop) |=> wdt_reset);
  // R4
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (count == '0));
  // R10
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_wr) |=> $stable(count));

  always_comb begin
    if (rst_n && bus_addr) begin
      // R7
      readback_chk: assert (bus_rdata == 8'h9A);
    end
  end
endmodule

bind wdt_guard wdt_guard_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_bitop(bus_bitop), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .tick(tick), .wdt_reset(wdt_reset),
  .halted(halted_w), .written(written_w), .count(count_w)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, bus_bitop = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic tick = 1'b0;
  logic wdt_reset;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_tag = "init";
  int exp_cyc[$];
  string exp_tag[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_bitop(bus_bitop), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick(tick), .wdt_reset(wdt_reset)
  );

  task automatic check_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  // Monitor: pops expected pulse cycles and compares
  always @(negedge clk) begin
    if (rst_n && wdt_reset) begin
      if (exp_cyc.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL %s: pulse at cycle %0d, expected none", cur_tag, cyc);
      end else begin
        automatic int e = exp_cyc.pop_front();
        automatic string t = exp_tag.pop_front();
        check_int(t, cyc, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int c, input string tag);
    exp_cyc.push_back(c);
    exp_tag.push_back(tag);
  endtask

  task automatic bus_op(input logic wr, input logic rd, input logic addr, input logic bitop,
                        input logic [7:0] d, input bit pulse, input string tag,
                        output int edge_no);
    @(negedge clk);
    cur_tag = tag;
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_bitop = bitop; bus_wdata = d;
    edge_no = cyc + 1;
    if (pulse) expect_at(cyc + 1, tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_bitop = 1'b0;
  endtask

  task automatic read_chk(input logic addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = addr; bus_rd = 1'b1; bus_bitop = 1'b0;
    #1;
    check_int(tag, int'(bus_rdata), int'(exp));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drain(input string tag);
    idle(3);
    check_int({tag, " pending pulses"}, exp_cyc.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0;
    exp_cyc.delete(); exp_tag.delete();
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    int e;
    int k;
    do_reset();
    // R9 / R7 reset state
    check_int("R9 reset pulse low", int'(wdt_reset), 0);
    read_chk(1'b0, 8'h67, "R7 setup reset value");
    read_chk(1'b1, 8'h9A, "R7 restart readback");

    // R1 one write accepted, second faults
    bus_op(1, 0, 0, 0, 8'h60, 0, "R1 first setup write", e);
    read_chk(1'b0, 8'h60, "R1 setup loaded");
    bus_op(1, 0, 0, 0, 8'h61, 1, "R1 second setup write", e);
    drain("R1");

    // R3 bad tag
    do_reset();
    bus_op(1, 0, 0, 0, 8'h40, 1, "R3 tag 010", e);
    drain("R3a");
    read_chk(1'b0, 8'h67, "R3 bad tag not loaded");
    do_reset();
    bus_op(1, 0, 0, 0, 8'hE0, 1, "R3 tag 111", e);
    drain("R3b");

    // R2 bit-level setup write
    do_reset();
    bus_op(1, 0, 0, 1, 8'h60, 1, "R2 bitop setup write", e);
    drain("R2");

    // R5 key and wrong key; R7 readback after key
    do_reset();
    bus_op(1, 0, 1, 0, 8'hAC, 0, "R5 correct key", e);
    read_chk(1'b1, 8'h9A, "R7 readback after key");
    bus_op(1, 0, 1, 0, 8'hAB, 1, "R5 wrong key AB", e);
    bus_op(1, 0, 1, 0, 8'h9A, 1, "R5 wrong key 9A", e);
    drain("R5");

    // R6 bit-level accesses to restart register
    bus_op(1, 0, 1, 1, 8'hAC, 1, "R6 bitop key write", e);
    bus_op(0, 1, 1, 1, 8'h00, 1, "R6 bitop restart read", e);
    drain("R6");

    // R8 overflow span 0 (16 ticks), repeating
    do_reset();
    bus_op(1, 0, 0, 0, 8'h60, 0, "R8 setup span0", e);
    tick = 1'b1;
    expect_at(e + 16, "R8 span0 first overflow");
    expect_at(e + 32, "R8 span0 second overflow");
    cur_tag = "R8 span0";
    while (cyc < e + 34) @(negedge clk);
    tick = 1'b0;
    drain("R8 span0");

    // R8 span 2 (64 ticks)
    do_reset();
    bus_op(1, 0, 0, 0, 8'h62, 0, "R8 setup span2", e);
    tick = 1'b1;
    expect_at(e + 64, "R8 span2 overflow");
    cur_tag = "R8 span2";
    while (cyc < e + 66) @(negedge clk);
    tick = 1'b0;
    drain("R8 span2");

    // R5 key mid-count restarts the count
    do_reset();
    bus_op(1, 0, 0, 0, 8'h60, 0, "R5 setup span0", e);
    tick = 1'b1;
    idle(8);
    bus_op(1, 0, 1, 0, 8'hAC, 0, "R5 key mid-count", k);
    expect_at(k + 16, "R5 overflow after key");
    cur_tag = "R5 key restart";
    while (cyc < k + 18) @(negedge clk);
    tick = 1'b0;
    drain("R5 key restart");

    // R10 no ticks, no overflow; then ticks start
    do_reset();
    bus_op(1, 0, 0, 0, 8'h60, 0, "R10 setup span0", e);
    cur_tag = "R10 no ticks";
    idle(60);
    drain("R10 no ticks");
    @(negedge clk);
    tick = 1'b1;
    k = cyc;
    expect_at(k + 16, "R10 overflow after ticks start");
    while (cyc < k + 18) @(negedge clk);
    tick = 1'b0;
    drain("R10 ticks");

    // R4 halt: frozen counter, later writes ignored
    do_reset();
    bus_op(1, 0, 0, 0, 8'h70, 0, "R4 halt setup", e);
    tick = 1'b1;
    cur_tag = "R4 halted ticking";
    idle(3000);
    bus_op(1, 0, 0, 0, 8'h00, 0, "R4 later write ignored", e);
    bus_op(1, 0, 0, 1, 8'h62, 0, "R4 later bitop ignored", e);
    idle(20);
    tick = 1'b0;
    drain("R4");
    read_chk(1'b0, 8'h70, "R4 setup unchanged");

    // R9 reset returns to post-reset state
    do_reset();
    read_chk(1'b0, 8'h67, "R9 setup after reset");
    bus_op(1, 0, 0, 0, 8'h61, 0, "R9 write accepted after reset", e);
    read_chk(1'b0, 8'h61, "R9 setup reloaded");
    drain("R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule